// File: doc/BRIEF.md
# Flash Page Lock and Debug-Lock Gate

This block guards on-chip flash and the debug port. After each reset it fetches a 16-byte protection structure from the tail of the highest flash page through a byte-read request port. It keeps that structure unchanged until the next reset. From then on it answers two request streams. Page write/erase requests carry a flash byte address and get an allow or deny verdict from the per-page protection bits. Debug command requests carry an 8-bit command code and get an allow or deny verdict from the latched debug-lock bit.

The flash read port splits into two parts. The request side (`rd_valid`/`rd_ready`/`rd_addr`) obeys valid/ready: once `rd_valid` is raised, it and `rd_addr` stay constant until `rd_ready` is seen high at a clock edge. The returned byte (`rd_dvalid`/`rd_data`) has no back-pressure, and bytes must come back in request order. Each verdict stream is valid/ready as well. A request transfers on an edge where both valid and ready are high. The verdict appears in a one-entry output register on the following cycle and stays there, unchanged, until its consumer raises ready. While an unconsumed verdict waits with its ready low, the matching request ready is low.

Top module: `flash_lockgate`

## Requirements
- R1: After reset the block requests the 16 bytes at addresses `LOCK_PAGE*PAGE_BYTES + PAGE_BYTES-16` upward, in ascending order, one per accepted handshake. `lock_ready` rises on the cycle after the 16th byte is returned, and it is 0 from reset until then.
- R2: A page request or command accepted while `lock_ready` is 0 is answered with deny.
- R3: For page index k below `FLASH_PAGES-1`, a request is allowed exactly when structure bit k is 1. Structure bit k is bit k%8 of byte k/8, where byte 0 is the lowest address. A 0 means the page is protected against write and erase.
- R4: The page index is the byte address divided by `PAGE_BYTES`. The highest page (index `FLASH_PAGES-1`, which holds the structure) is allowed only when the debug lock is open, and its own page bit is ignored. Any index above it is always denied. Structure bits for absent pages have no effect.
- R5: The debug-lock bit is structure bit 127 (bit 7 of byte 15), and 1 means open. While it is 0, only codes 8'h10 (chip erase), 8'h30 (read status) and 8'h68 (get chip ID) are allowed, and all others are denied. While it is 1, every code is allowed.
- R6: Once `lock_ready` is 1, returned bytes that nobody requested have no effect on `dbg_open` or on any verdict. Only a new reset reloads the structure, and a reset does pick up changed flash contents.
- R7: `dbg_open` reports the latched debug-lock bit, and it is 0 until `lock_ready` is 1.
- R8: Each accepted request produces exactly one verdict, in order. A verdict is held stable while its ready is low, and during that time the matching request ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | output | 1 | Flash byte-read request valid |
| rd_ready | input | 1 | Flash accepts the read request |
| rd_addr | output | ADDR_W | Flash byte address being requested |
| rd_dvalid | input | 1 | Returned byte valid |
| rd_data | input | 8 | Returned byte |
| req_valid | input | 1 | Page write/erase request valid |
| req_ready | output | 1 | Page request accepted |
| req_addr | input | ADDR_W | Byte address of the page request |
| resp_valid | output | 1 | Page verdict valid |
| resp_ready | input | 1 | Consumer takes the page verdict |
| resp_allow | output | 1 | 1 = page operation allowed |
| cmd_valid | input | 1 | Debug command valid |
| cmd_ready | output | 1 | Debug command accepted |
| cmd_code | input | 8 | Debug command code |
| cmd_resp_valid | output | 1 | Command verdict valid |
| cmd_resp_ready | input | 1 | Consumer takes the command verdict |
| cmd_allow | output | 1 | 1 = command may run |
| lock_ready | output | 1 | Protection structure fully loaded |
| dbg_open | output | 1 | Latched debug-lock bit (1 = unlocked) |

## Verification
The page check is driven in two setups. One has an alternating byte-0 pattern with a closed debug lock. The other has an open debug lock and a cleared page bit for the highest page. Comparing them shows whether the decision reads the correct bit position and polarity, and whether the structure page uses the debug bit rather than its own page bit. Addresses at the last normal page, the structure page and above it show whether the index boundary is off by one. The command filter is tried with the three privileged codes and with ordinary codes under both lock states. Requests sent during a throttled load, stray returned bytes after loading, and a held-off consumer show whether the block respects load order, freezes the structure and handles back-pressure.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam int STRUCT_BYTES = 16;
  localparam int STRUCT_BITS  = STRUCT_BYTES * 8;
  localparam int DBG_BIT      = STRUCT_BITS - 1;

  localparam logic [7:0] CODE_CHIP_ERASE = 8'h10;
  localparam logic [7:0] CODE_RD_STATUS  = 8'h30;
  localparam logic [7:0] CODE_CHIP_ID    = 8'h68;

  function automatic logic is_privileged(input logic [7:0] code);
    return (code == CODE_CHIP_ERASE) || (code == CODE_RD_STATUS) ||
           (code == CODE_CHIP_ID);
  endfunction
endpackage

// File: rtl/flk_lock_loader.sv
module flk_lock_loader
  import flk_pkg::*;
#(
  parameter int FLASH_PAGES = 64,
  parameter int PAGE_BYTES  = 2048,
  parameter int ADDR_W      = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [ADDR_W-1:0]      rd_addr,
  input  logic                   rd_dvalid,
  input  logic [7:0]             rd_data,
  output logic [STRUCT_BITS-1:0] lock_vec,
  output logic                   loaded
);
  localparam int CNT_W = $clog2(STRUCT_BYTES + 1);
  localparam int BASE  = FLASH_PAGES * PAGE_BYTES - STRUCT_BYTES;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(STRUCT_BYTES);

  logic                   run_q;
  logic [CNT_W-1:0]       issue_cnt;
  logic [CNT_W-1:0]       rcv_cnt;
  logic [STRUCT_BITS-1:0] lock_q;

  assign rd_valid = run_q && (issue_cnt != LAST);
  assign rd_addr  = BASE_A + ADDR_W'(issue_cnt);
  assign loaded   = (rcv_cnt == LAST);
  assign lock_vec = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      issue_cnt <= '0;
      rcv_cnt   <= '0;
      lock_q    <= '0;
    end else begin
      run_q <= 1'b1;
      if (rd_valid && rd_ready) issue_cnt <= issue_cnt + 1'b1;
      if (rd_dvalid && !loaded) begin
        lock_q[{rcv_cnt[3:0], 3'b000} +: 8] <= rd_data;
        rcv_cnt <= rcv_cnt + 1'b1;
      end
    end
  end

  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (!rd_valid || rd_addr == $past(rd_addr) + 1'b1)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R1
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded); // R6
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> $stable(lock_vec)); // R6
endmodule

// File: rtl/flk_page_guard.sv
module flk_page_guard
  import flk_pkg::*;
#(
  parameter int FLASH_PAGES = 64,
  parameter int PAGE_BYTES  = 2048,
  parameter int ADDR_W      = 18
) (
  input  logic                   loaded,
  input  logic [STRUCT_BITS-1:0] lock_vec,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   allow
);
  localparam int PG_SH = $clog2(PAGE_BYTES);
  localparam int IDX_W = ADDR_W - PG_SH;
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(FLASH_PAGES - 1);

  logic [IDX_W-1:0] idx;
  logic [6:0]       idx_lo;
  logic             page_open;

  assign idx    = addr[ADDR_W-1:PG_SH];
  assign idx_lo = 7'(idx);

  always_comb begin
    page_open = 1'b0;
    if (idx < LOCK_IDX)       page_open = lock_vec[idx_lo];
    else if (idx == LOCK_IDX) page_open = lock_vec[DBG_BIT];
    allow = loaded && page_open;
  end
endmodule

// File: rtl/flk_cmd_filter.sv
module flk_cmd_filter
  import flk_pkg::*;
(
  input  logic       loaded,
  input  logic       dbg_bit,
  input  logic [7:0] code,
  output logic       allow
);
  assign allow = loaded && (dbg_bit || is_privileged(code));
endmodule

// File: rtl/flk_resp_slot.sv
module flk_resp_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_allow,
  output logic out_valid,
  input  logic out_ready,
  output logic out_allow
);
  logic valid_q, allow_q;

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_allow = allow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      valid_q <= 1'b1;
      allow_q <= in_allow;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_allow))); // R8
  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

// File: rtl/flash_lockgate.sv
module flash_lockgate
  import flk_pkg::*;
#(
  parameter int FLASH_PAGES = 64,
  parameter int PAGE_BYTES  = 2048,
  parameter int ADDR_W      = $clog2(FLASH_PAGES * PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_dvalid,
  input  logic [7:0]        rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_allow,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  output logic              cmd_resp_valid,
  input  logic              cmd_resp_ready,
  output logic              cmd_allow,
  output logic              lock_ready,
  output logic              dbg_open
);
  localparam int PG_SH = $clog2(PAGE_BYTES);
  localparam int IDX_W = ADDR_W - PG_SH;

  logic [STRUCT_BITS-1:0] lock_vec;
  logic                   loaded;
  logic                   page_ok, cmd_ok;

  flk_lock_loader #(.FLASH_PAGES(FLASH_PAGES), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W))
  u_loader (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_dvalid(rd_dvalid), .rd_data(rd_data),
    .lock_vec(lock_vec), .loaded(loaded)
  );

  flk_page_guard #(.FLASH_PAGES(FLASH_PAGES), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W))
  u_guard (.loaded(loaded), .lock_vec(lock_vec), .addr(req_addr), .allow(page_ok));

  flk_cmd_filter u_filter (
    .loaded(loaded), .dbg_bit(lock_vec[DBG_BIT]), .code(cmd_code), .allow(cmd_ok)
  );

  flk_resp_slot u_page_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_allow(page_ok), .out_valid(resp_valid), .out_ready(resp_ready),
    .out_allow(resp_allow)
  );

  flk_resp_slot u_cmd_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_ready(cmd_ready),
    .in_allow(cmd_ok), .out_valid(cmd_resp_valid), .out_ready(cmd_resp_ready),
    .out_allow(cmd_allow)
  );

  assign lock_ready = loaded;
  assign dbg_open   = loaded && lock_vec[DBG_BIT];

  logic req_fire, cmd_fire, idx_above;
  assign req_fire  = req_valid && req_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign idx_above = req_addr[ADDR_W-1:PG_SH] > IDX_W'(FLASH_PAGES - 1);

  AST_EARLY_PAGE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !lock_ready) |=> !resp_allow); // R2
  AST_EARLY_CMD_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !lock_ready) |=> !cmd_allow); // R2
  AST_OOR_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && idx_above) |=> !resp_allow); // R4
  AST_LOCKED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !dbg_open && !is_privileged(cmd_code)) |=> !cmd_allow); // R5
  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ready |-> !dbg_open); // R7
endmodule

// File: tb/flash_lockgate_bench.sv
module flash_lockgate_bench;
  localparam int P      = 64;
  localparam int PB     = 2048;
  localparam int AW     = 18;
  localparam int BASE   = P * PB - 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rd_valid, rd_ready, rd_dvalid;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          req_valid, req_ready, resp_valid, resp_ready, resp_allow;
  logic [AW-1:0] req_addr;
  logic          cmd_valid, cmd_ready, cmd_resp_valid, cmd_resp_ready, cmd_allow;
  logic [7:0]    cmd_code;
  logic          lock_ready, dbg_open;

  flash_lockgate #(.FLASH_PAGES(P), .PAGE_BYTES(PB), .ADDR_W(AW)) u_flash_lockgate (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_dvalid(rd_dvalid), .rd_data(rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_allow(resp_allow),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_resp_valid(cmd_resp_valid), .cmd_resp_ready(cmd_resp_ready),
    .cmd_allow(cmd_allow), .lock_ready(lock_ready), .dbg_open(dbg_open)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [16];
  int beats = 0;
  int expect_n = 0;
  bit stall_en = 1'b0;
  bit inj_on = 1'b0;
  logic [7:0] inj_data = 8'h00;
  bit pq[$];  string pt[$];
  bit cq[$];  string ct[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash byte-read model, one cycle return latency
  initial begin
    rd_ready = 1'b1; rd_dvalid = 1'b0; rd_data = 8'h00;
    forever begin
      bit cap;
      logic [AW-1:0] a;
      @(negedge clk);
      cap = rst_n && rd_valid && rd_ready;
      a = rd_addr;
      @(posedge clk);
      #1;
      if (cap) begin
        check("R1 read address order", 32'(a), 32'(BASE + expect_n));
        expect_n++;
        rd_dvalid = 1'b1;
        rd_data = mem[4'(a - AW'(BASE))];
        beats++;
      end else if (inj_on) begin
        rd_dvalid = 1'b1;
        rd_data = inj_data;
      end else begin
        rd_dvalid = 1'b0;
      end
      rd_ready = stall_en ? ($time % 24 != 1) && ($time % 3 != 0) : 1'b1;
    end
  end

  function automatic bit pred_page(input logic [AW-1:0] a, input bit ready);
    int idx = int'(a) / PB;
    if (!ready) return 1'b0;
    if (idx < P - 1) return mem[idx / 8][idx % 8];
    if (idx == P - 1) return mem[15][7];
    return 1'b0;
  endfunction

  function automatic bit pred_cmd(input logic [7:0] c, input bit ready);
    if (!ready) return 1'b0;
    return mem[15][7] || c == 8'h10 || c == 8'h30 || c == 8'h68;
  endfunction

  task automatic send_page(input logic [AW-1:0] a, input bit exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    pq.push_back(exp); pt.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c, input bit exp, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    cq.push_back(exp); ct.push_back(tag);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // scoreboard monitors
  initial forever begin
    @(negedge clk); #2;
    if (resp_valid && resp_ready) begin
      if (pq.size() == 0) check("R8 unexpected page verdict", 1, 0);
      else check(pt.pop_front(), 32'(resp_allow), 32'(pq.pop_front()));
    end
    if (cmd_resp_valid && cmd_resp_ready) begin
      if (cq.size() == 0) check("R8 unexpected command verdict", 1, 0);
      else check(ct.pop_front(), 32'(cmd_allow), 32'(cq.pop_front()));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; beats = 0; expect_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_loaded();
    wait (beats == 16);
    check("R1 not ready before last byte taken", 32'(lock_ready), 0);
    @(posedge clk); #1;
    check("R1 ready after 16 bytes", 32'(lock_ready), 1);
  endtask

  task automatic drain();
    while (pq.size() != 0 || cq.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    check("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 0; req_addr = '0; resp_ready = 1;
    cmd_valid = 0; cmd_code = '0; cmd_resp_ready = 1;
    foreach (mem[i]) mem[i] = 8'(i * 37 + 3);
    mem[0] = 8'b1010_0101;
    mem[5] = 8'h40;   // page 46 open
    mem[7] = 8'hFF;   // page 63 bit set but ignored
    mem[15] = 8'h7F;  // debug locked
    stall_en = 1'b1;
    #1;
    check("R1 reset lock_ready", 32'(lock_ready), 0);
    check("R7 reset dbg_open", 32'(dbg_open), 0);
    do_reset();
    // R2: requests during throttled load
    send_page(AW'(0 * PB), 1'b0, "R2 early page deny");
    send_cmd(8'h30, 1'b0, "R2 early command deny");
    check("R2 still loading", 32'(lock_ready), 0);
    wait_loaded();
    stall_en = 1'b0;
    check("R7 dbg_open locked", 32'(dbg_open), 0);
    drain();
    // R3 bit polarity / position
    for (int k = 0; k < 8; k++)
      send_page(AW'(k * PB + 5), pred_page(AW'(k * PB), 1), $sformatf("R3 page %0d", k));
    send_page(AW'(46 * PB), 1'b1, "R3 page 46 open");
    send_page(AW'(45 * PB), pred_page(AW'(45 * PB), 1), "R3 page 45");
    send_page(AW'(62 * PB + PB - 1), pred_page(AW'(62 * PB), 1), "R4 last normal page");
    send_page(AW'(63 * PB), 1'b0, "R4 lock page with debug locked");
    send_page(AW'(64 * PB), 1'b0, "R4 above lock page");
    send_page(AW'(100 * PB), 1'b0, "R4 far above");
    // R5 command filter locked
    send_cmd(8'h10, 1'b1, "R5 chip erase passes lock");
    send_cmd(8'h30, 1'b1, "R5 read status passes lock");
    send_cmd(8'h68, 1'b1, "R5 chip id passes lock");
    send_cmd(8'h20, 1'b0, "R5 ordinary code blocked");
    send_cmd(8'h00, 1'b0, "R5 code 00 blocked");
    send_cmd(8'hFF, 1'b0, "R5 code FF blocked");
    drain();
    // R8 back-pressure
    @(negedge clk); resp_ready = 1'b0;
    send_page(AW'(0), pred_page(AW'(0), 1), "R8 held verdict 1");
    repeat (3) @(negedge clk);
    #1;
    check("R8 verdict held valid", 32'(resp_valid), 1);
    check("R8 verdict held value", 32'(resp_allow), 32'(pred_page(AW'(0), 1)));
    check("R8 request stalled", 32'(req_ready), 0);
    fork
      send_page(AW'(1 * PB), pred_page(AW'(PB), 1), "R8 queued verdict 2");
      begin repeat (4) @(negedge clk); resp_ready = 1'b1; end
    join
    drain();
    // R6 stray bytes after load
    inj_data = 8'hFF; inj_on = 1'b1;
    repeat (4) @(negedge clk);
    inj_data = 8'h00;
    repeat (4) @(negedge clk);
    inj_on = 1'b0;
    @(negedge clk); #1;
    check("R6 dbg_open unchanged", 32'(dbg_open), 0);
    send_page(AW'(1 * PB), 1'b0, "R6 page 1 still locked");
    send_cmd(8'h20, 1'b0, "R6 command still blocked");
    drain();
    // second setup: debug open, reload after reset
    mem[0] = 8'b0101_1010;
    mem[7] = 8'h7F;   // page 63 bit cleared but ignored
    mem[15] = 8'h80;
    do_reset();
    check("R6 reset clears ready", 32'(lock_ready), 0);
    wait_loaded();
    check("R7 dbg_open open", 32'(dbg_open), 1);
    send_page(AW'(0), 1'b0, "R3 page 0 after reload");
    send_page(AW'(1 * PB), 1'b1, "R3 page 1 after reload");
    send_page(AW'(63 * PB + 17), 1'b1, "R4 lock page with debug open");
    send_page(AW'(64 * PB), 1'b0, "R4 above lock page open");
    send_cmd(8'h20, 1'b1, "R5 ordinary code when open");
    send_cmd(8'h10, 1'b1, "R5 chip erase when open");
    drain();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule